// File: doc/BRIEF.md
# Shared-Term Carry-Select Adder

This block is a combinational N-bit adder that takes two operands and a carry-in and returns an N-bit sum and a carry-out. The operand width is split into groups. Inside each group the adder does not build two complete ripple adders, one for each possible incoming carry. Instead, each bit computes a single XOR half-sum and a single AND generate term, and both carry assumptions reuse them.

The candidate sum for an incoming carry of zero is built from XOR gates. The candidate sum for an incoming carry of one is built the same way, except at the lowest bit of the group, where it is the inverted half-sum. Only the carry logic is duplicated: two short AND/OR chains, one starting from a fixed 0 and one from a fixed 1.

The real carry arriving at a group drives a multiplexer that picks the right candidates. The selected carry-out then feeds the next group.

A parameter chooses between two selection styles. In the first, the group's whole sum vector and its carry are muxed. In the second, each bit muxes its incoming carry and XORs it with the half-sum.

Top module: `shared_csa_adder`

## Requirements
- R1: For every value of `a`, `b` and `cin`, `{cout, sum}` equals `a + b + cin`. At the default 8-bit width this holds over all 131072 input combinations.
- R2: When `a & b` is all zeros and `cin` is 0, `sum` equals `a ^ b` and `cout` is 0. This includes the all-zero inputs applied right after reset.
- R3: When `a ^ b` is all ones, a full propagate, the carry-in passes through every group. With `cin` = 1, `sum` is all zeros and `cout` is 1. With `cin` = 0, `sum` is all ones and `cout` is 0.
- R4: When the top bits of `a` and `b` are both 1, `cout` is 1 whatever the other inputs are.
- R5: When the top bits of `a` and `b` are both 0, `cout` is 0 whatever the other inputs are.
- R6: A carry generated at the top bit of one group reaches the lowest bit of the next group. With `a` = `b` = 2^(GROUP-1) and `cin` = 0, `sum` is 2^GROUP and `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a    | input  | WIDTH | First operand |
| b    | input  | WIDTH | Second operand |
| cin  | input  | 1     | Carry into bit 0 |
| sum  | output | WIDTH | Sum bits |
| cout | output | 1     | Carry out of the top bit |

## Verification
The two group functions that can act in the same evaluation are candidate selection inside a group and the carry hand-off into the next group. An all-propagate operand pair with `cin` = 1 forces every group multiplexer to take its carry-one candidate while that same carry travels through to `cout`. The uneven default split (3, 3 and 2 bits) means a carry crossing the narrow last group is also exercised. Each case is judged against an independent integer sum of the operands, both at the outputs and by a full sweep of every input combination.

// File: rtl/csa_pkg.sv
package csa_pkg;

   typedef enum logic [0:0] {
      SEL_GROUP = 1'b0,
      SEL_BIT   = 1'b1
   } sel_style_e;

   function automatic int num_groups(input int width, input int group);
      return (width + group - 1) / group;
   endfunction

endpackage

// File: rtl/csa_share_group.sv
module csa_share_group #(
   parameter int GW = 4
) (
   input  logic [GW-1:0] a,
   input  logic [GW-1:0] b,
   output logic [GW-1:0] hsum,
   output logic [GW-1:0] s_zero,
   output logic [GW-1:0] s_one,
   output logic [GW-1:0] c_zero,
   output logic [GW-1:0] c_one
);

   logic [GW-1:0] gen;

   always_comb begin
      hsum      = a ^ b;
      gen       = a & b;
      // Lowest bit: the two hypotheses differ only by an inverter on the half-sum.
      s_zero[0] = hsum[0];
      s_one[0]  = ~hsum[0];
      c_zero[0] = gen[0];
      c_one[0]  = gen[0] | hsum[0];
      for (int i = 1; i < GW; i++) begin
         c_zero[i] = gen[i] | (hsum[i] & c_zero[i-1]);
         c_one[i]  = gen[i] | (hsum[i] & c_one[i-1]);
         s_zero[i] = hsum[i] ^ c_zero[i-1];
         s_one[i]  = hsum[i] ^ c_one[i-1];
      end
   end

endmodule

// File: rtl/csa_select.sv
module csa_select
   import csa_pkg::*;
#(
   parameter int         GW    = 4,
   parameter sel_style_e STYLE = SEL_GROUP
) (
   input  logic          gcin,
   input  logic [GW-1:0] hsum,
   input  logic [GW-1:0] s_zero,
   input  logic [GW-1:0] s_one,
   input  logic [GW-1:0] c_zero,
   input  logic [GW-1:0] c_one,
   output logic [GW-1:0] sum,
   output logic          gcout
);

   assign gcout = gcin ? c_one[GW-1] : c_zero[GW-1];

   if (STYLE == SEL_GROUP) begin : g_grp_mux
      assign sum = gcin ? s_one : s_zero;
   end else begin : g_bit_mux
      logic [GW-1:0] cin_bit;
      always_comb begin
         cin_bit[0] = gcin;
         for (int i = 1; i < GW; i++) begin
            cin_bit[i] = gcin ? c_one[i-1] : c_zero[i-1];
         end
      end
      assign sum = hsum ^ cin_bit;
   end

endmodule

// File: rtl/shared_csa_adder.sv
module shared_csa_adder
   import csa_pkg::*;
#(
   parameter int         WIDTH = 8,
   parameter int         GROUP = 3,
   parameter sel_style_e STYLE = SEL_GROUP
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   localparam int NGRP = num_groups(WIDTH, GROUP);

   if (WIDTH < 1) begin : g_bad_width
      $error("shared_csa_adder: WIDTH must be at least 1");
   end
   if (GROUP < 1 || GROUP > WIDTH) begin : g_bad_group
      $error("shared_csa_adder: GROUP must lie in 1..WIDTH");
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int LO = g * GROUP;
      localparam int GW = (WIDTH - LO < GROUP) ? (WIDTH - LO) : GROUP;

      logic          gcin;
      logic          gcout;
      logic [GW-1:0] hsum, s_zero, s_one, c_zero, c_one;

      if (g == 0) begin : g_first
         assign gcin = cin;
      end else begin : g_next
         assign gcin = g_grp[g-1].gcout;
      end

      csa_share_group #(.GW(GW)) u_share (
         .a      (a[LO +: GW]),
         .b      (b[LO +: GW]),
         .hsum   (hsum),
         .s_zero (s_zero),
         .s_one  (s_one),
         .c_zero (c_zero),
         .c_one  (c_one)
      );

      csa_select #(.GW(GW), .STYLE(STYLE)) u_sel (
         .gcin   (gcin),
         .hsum   (hsum),
         .s_zero (s_zero),
         .s_one  (s_one),
         .c_zero (c_zero),
         .c_one  (c_one),
         .sum    (sum[LO +: GW]),
         .gcout  (gcout)
      );
   end

   assign cout = g_grp[NGRP-1].gcout;

endmodule

// File: rtl/shared_csa_adder_chk.sv
module shared_csa_adder_chk #(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic             cin,
   input logic [WIDTH-1:0] sum,
   input logic             cout
);

   logic [WIDTH:0] total;

   always_comb begin
      total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
      AST_EXACT_SUM: assert ({cout, sum} == total); // R1
      if ((a & b) == '0 && !cin) begin
         AST_NO_GENERATE: assert (sum == (a ^ b) && !cout); // R2
      end
      if ((a ^ b) == '1) begin
         AST_FULL_PROPAGATE: assert (cout == cin && sum == {WIDTH{~cin}}); // R3
      end
      if (a[WIDTH-1] && b[WIDTH-1]) begin
         AST_MSB_GENERATE: assert (cout); // R4
      end
      if (!a[WIDTH-1] && !b[WIDTH-1]) begin
         AST_MSB_KILL: assert (!cout); // R5
      end
   end

endmodule

bind shared_csa_adder shared_csa_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/shared_csa_adder_bench.sv
module shared_csa_adder_bench;

   localparam int W = 8;
   localparam int G = 3;

   typedef struct {
      logic [W-1:0] sum;
      logic         cout;
      string        req;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic         cin = 1'b0;
   logic [W-1:0] sum;
   logic         cout;

   exp_t queue_q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   bit   drv_done = 1'b0;
   int   cycles   = 0;

   always #4 clk = ~clk;

   shared_csa_adder #(.WIDTH(W), .GROUP(G)) u_shared_csa_adder (
      .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
   );

   task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb,
                        input logic vc, input string req);
      logic [W:0] t;
      exp_t e;
      @(posedge clk);
      #1;
      a   = va;
      b   = vb;
      cin = vc;
      t = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
      e.sum  = t[W-1:0];
      e.cout = t[W];
      e.req  = req;
      queue_q.push_back(e);
   endtask

   // Monitor: compares mid-cycle, away from the rising edge.
   always @(negedge clk) begin
      if (rst_n && queue_q.size() > 0) begin
         exp_t e;
         e = queue_q.pop_front();
         n_checks++;
         if (sum !== e.sum || cout !== e.cout) begin
            n_fail++;
            $display("FAIL %s a=%0h b=%0h cin=%0b: got sum=%0h cout=%0b, expected sum=%0h cout=%0b",
                     e.req, a, b, cin, sum, cout, e.sum, e.cout);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      drive(8'h00, 8'h00, 1'b0, "R2 reset-state zero");
      drive(8'hA5, 8'h5A, 1'b0, "R2 disjoint bits");
      drive(8'h0F, 8'h30, 1'b0, "R2 disjoint bits");
      drive(8'hFF, 8'h00, 1'b1, "R3 propagate cin=1");
      drive(8'hAA, 8'h55, 1'b1, "R3 propagate cin=1");
      drive(8'h3C, 8'hC3, 1'b0, "R3 propagate cin=0");
      drive(8'h80, 8'h80, 1'b0, "R4 msb generate");
      drive(8'hC1, 8'h87, 1'b1, "R4 msb generate");
      drive(8'h7F, 8'h7F, 1'b1, "R5 msb kill");
      drive(8'h40, 8'h3F, 1'b1, "R5 msb kill");
      drive(8'h04, 8'h04, 1'b0, "R6 group boundary 0->1");
      drive(8'h20, 8'h20, 1'b0, "R6 group boundary 1->2");
      drive(8'h07, 8'h01, 1'b0, "R6 ripple into group 1");
      for (int x = 0; x < 2 * 65536; x++) begin
         drive(x[7:0], x[15:8], x[16], "R1 exhaustive");
      end
      @(posedge clk);
      @(posedge clk);
      drv_done = 1'b1;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got %0d cycles, expected at most 190000", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
      if (drv_done && queue_q.size() == 0) begin
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule